// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits between a data-moving engine and the system interconnect. It translates every 32-bit address the engine issues into a target identifier and an attribute byte, and it gives a high address word for remapping. It compares the request against eight programmable windows. Each window is a naturally aligned region whose size is a multiple of 64 KiB. It is described by a base word and a size word. The first four windows also carry a high remap word.

Two enable words exist, one for each requester port. Each enable word switches windows on and gives every window a two-bit access right. The request's port bit selects which enable word applies. When a request misses every window, or when its direction is not allowed by the winning window, the block raises a one-cycle decode-error flag beside the response. The decode itself is combinational, and all results appear one clock after the request through a single registered output stage. Configuration is written through a simple indexed write port.

Top module: `xwd_top`

## Requirements
- R1: After reset every base, size, remap and enable word is zero, so every window is disabled and every request misses; `rsp_valid` and `rsp_err` are 0 until a request arrives.
- R2: Window i hits when its enable bit is set and `addr[31:16] & ~size[31:16]` equals `base[31:16] & ~size[31:16]`; address bits [15:0] never affect the decode.
- R3: Configuration index map on `cfg_addr`: 0..7 base word of window 0..7, 8..15 size word of window 0..7, 16..19 remap word of window 0..3, 20 enable word for port 0, 21 enable word for port 1, 22..23 override slots; other indices are ignored.
- R4: The base word holds the region start in bits [31:16], the attribute in bits [15:8] and the target identifier in bits [3:0]; the size word holds (size − 1) in bits [31:16].
- R5: In an enable word, bit i enables window i and bits [17+2i:16+2i] are that window's access right.
- R6: `req_port` (0 or 1) selects enable word 20 or 21 for the request, so the same address may hit or miss, or be allowed or refused, depending on the port.
- R7: When several windows hit, the lowest-numbered window wins and its fields are reported.
- R8: Access right 01 allows reads only, 11 allows reads and writes, 00 and 10 allow nothing; a refused hit gives `rsp_hit`=1, `rsp_ok`=0 and `rsp_err`=1, with the window's own target and attribute.
- R9: A miss gives `rsp_hit`=0, `rsp_ok`=0, `rsp_err`=1, `rsp_win`=0, `rsp_target`=4'hF (invalid), `rsp_attr`=0 and `rsp_remap`=0.
- R10: `rsp_remap` is the remap word of the winning window when that window is 0..3, and zero for windows 4..7.
- R11: Every response appears exactly one clock after its request (`rsp_valid` follows `req_valid` by one cycle), and `rsp_err` is never high without `rsp_valid`.
- R12: Writes to the override slots (22, 23) are accepted and change no decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request direction, 1 = write |
| req_port | input | 1 | Requester port, selects the enable word |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_ok | output | 1 | Hit and direction allowed |
| rsp_err | output | 1 | Decode-error pulse (miss or refused) |
| rsp_win | output | 3 | Winning window number |
| rsp_target | output | 4 | Target identifier |
| rsp_attr | output | 8 | Target attribute |
| rsp_remap | output | 32 | High remap word |

## Verification
On every cycle the assertions check the one-cycle response timing, that an error never appears without a response, that a miss always carries the error and the invalid target, that the error flag is the exact complement of the access verdict on a hit, and that windows without remap report a zero remap word. The match rule, lowest-window priority, port selection of the enable word, access encodings, field layouts and the inert override slots depend on the programmed contents, so only the bench's sweeps show them. Those sweeps compare every response against a model built from the values the bench itself wrote. They cover the full top address byte under several middle bytes, both ports and both directions.

// File: rtl/xwd_pkg.sv
package xwd_pkg;
  // granularity of a window: low address bits ignored by the decode
  localparam int GRAN_LSB = 16;
  // field positions inside a base word
  localparam int ATTR_LSB = 8;
  localparam int ATTR_W   = 8;
  localparam int TGT_W    = 4;
  // access right field positions inside an enable word
  localparam int ACC_LSB  = 16;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_RSV  = 2'b10,
    ACC_RW   = 2'b11
  } acc_e;

  function automatic logic acc_allows(input logic [1:0] acc, input logic wr);
    if (wr) return acc == ACC_RW;
    return (acc == ACC_RO) || (acc == ACC_RW);
  endfunction
endpackage

// File: rtl/xwd_regs.sv
module xwd_regs #(
  parameter int NWIN   = 8,
  parameter int NREMAP = 4,
  parameter int NPORT  = 2,
  parameter int DW     = 32,
  parameter int CAW    = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [CAW-1:0]              cfg_addr,
  input  logic [DW-1:0]               cfg_wdata,
  output logic [NWIN-1:0][DW-1:0]     base_q,
  output logic [NWIN-1:0][DW-1:0]     size_q,
  output logic [NREMAP-1:0][DW-1:0]   remap_q,
  output logic [NPORT-1:0][DW-1:0]    en_q
);
  localparam int OFS_SIZE  = NWIN;
  localparam int OFS_REMAP = 2 * NWIN;
  localparam int OFS_EN    = OFS_REMAP + NREMAP;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CAW'(i))            base_q[i] <= cfg_wdata;
        if (cfg_addr == CAW'(OFS_SIZE + i)) size_q[i] <= cfg_wdata;
      end
    end
  end

  for (genvar r = 0; r < NREMAP; r++) begin : g_remap
    always_ff @(posedge clk) begin
      if (rst)                                          remap_q[r] <= '0;
      else if (cfg_we && cfg_addr == CAW'(OFS_REMAP + r)) remap_q[r] <= cfg_wdata;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst)                                       en_q[p] <= '0;
      else if (cfg_we && cfg_addr == CAW'(OFS_EN + p)) en_q[p] <= cfg_wdata;
    end
  end
  // override slots follow the enable words; they hold no state and read as zero
endmodule

// File: rtl/xwd_match.sv
module xwd_match #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  parameter int GL   = 16
) (
  input  logic [DW-1:0]           addr,
  input  logic [DW-1:0]           en_word,
  input  logic [NWIN-1:0][DW-1:0] base_q,
  input  logic [NWIN-1:0][DW-1:0] size_q,
  output logic [NWIN-1:0]         hit_vec
);
  localparam int HW = DW - GL;

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    logic [HW-1:0] mask;
    assign mask       = ~size_q[i][DW-1:GL];
    assign hit_vec[i] = en_word[i] &&
                        ((addr[DW-1:GL] & mask) == (base_q[i][DW-1:GL] & mask));
  end
endmodule

// File: rtl/xwd_prio.sv
module xwd_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xwd_top.sv
module xwd_top
  import xwd_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int NREMAP = 4,
  parameter int NPORT  = 2,
  parameter int DW     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [$clog2(2*NWIN+NREMAP+2*NPORT)-1:0] cfg_addr,
  input  logic [DW-1:0]                cfg_wdata,
  input  logic                         req_valid,
  input  logic [DW-1:0]                req_addr,
  input  logic                         req_write,
  input  logic [$clog2(NPORT)-1:0]     req_port,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic                         rsp_ok,
  output logic                         rsp_err,
  output logic [$clog2(NWIN)-1:0]      rsp_win,
  output logic [TGT_W-1:0]             rsp_target,
  output logic [ATTR_W-1:0]            rsp_attr,
  output logic [DW-1:0]                rsp_remap
);
  localparam int CAW = $clog2(2*NWIN + NREMAP + 2*NPORT);
  localparam int WIW = $clog2(NWIN);
  localparam int RIW = (NREMAP > 1) ? $clog2(NREMAP) : 1;

  logic [NWIN-1:0][DW-1:0]   base_q, size_q;
  logic [NREMAP-1:0][DW-1:0] remap_q;
  logic [NPORT-1:0][DW-1:0]  en_q;
  logic [DW-1:0]             en_sel;
  logic [NWIN-1:0]           hit_vec;
  logic                      any_hit;
  logic [WIW-1:0]            win_idx;
  logic [1:0]                acc;
  logic                      allow;
  logic [DW-1:0]             remap_sel;

  xwd_regs #(.NWIN(NWIN), .NREMAP(NREMAP), .NPORT(NPORT), .DW(DW), .CAW(CAW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .base_q(base_q), .size_q(size_q), .remap_q(remap_q), .en_q(en_q)
  );

  assign en_sel = en_q[req_port];

  xwd_match #(.NWIN(NWIN), .DW(DW), .GL(GRAN_LSB)) u_match (
    .addr(req_addr), .en_word(en_sel), .base_q(base_q), .size_q(size_q), .hit_vec(hit_vec)
  );

  xwd_prio #(.N(NWIN), .IW(WIW)) u_prio (
    .req(hit_vec), .any(any_hit), .idx(win_idx)
  );

  assign acc       = en_sel[ACC_LSB + 2*win_idx +: 2];
  assign allow     = any_hit && acc_allows(acc, req_write);
  assign remap_sel = (int'(win_idx) < NREMAP) ? remap_q[RIW'(win_idx)] : '0;

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !allow;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      rsp_hit <= any_hit;
      rsp_ok  <= allow;
      if (any_hit) begin
        rsp_win    <= win_idx;
        rsp_target <= base_q[win_idx][TGT_W-1:0];
        rsp_attr   <= base_q[win_idx][ATTR_LSB +: ATTR_W];
        rsp_remap  <= remap_sel;
      end else begin
        rsp_win    <= '0;
        rsp_target <= '1;
        rsp_attr   <= '0;
        rsp_remap  <= '0;
      end
    end
  end

  // R11: a request is answered on the next cycle
  a_r11_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R11: no response without a request one cycle earlier
  a_r11_origin: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
  // R11: the error pulse only accompanies a response
  a_r11_err_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
  // R9: a miss carries the error and the invalid target
  a_r9_miss: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_err && !rsp_ok && rsp_target == '1));
  // R8: on a hit, the error is the complement of the access verdict
  a_r8_verdict: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_err == !rsp_ok));
  // R10: windows without a remap word report zero
  a_r10_no_remap: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && int'(rsp_win) >= NREMAP) |-> (rsp_remap == '0));
endmodule

// File: tb/sim_xwd_top.sv
module sim_xwd_top;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_port = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_ok, rsp_err;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_remap;

  int checks = 0;
  int errors = 0;

  // bench copy of what it programmed
  logic [31:0] m_base [NWIN];
  logic [31:0] m_size [NWIN];
  logic [31:0] m_remap[4];
  logic [31:0] m_en   [2];

  xwd_top u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_port(req_port),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_remap(rsp_remap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wr_cfg(input int idx, input logic [31:0] val);
    cfg_we    = 1'b1;
    cfg_addr  = 5'(idx);
    cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 8)       m_base[idx]      = val;
    else if (idx < 16) m_size[idx-8]    = val;
    else if (idx < 20) m_remap[idx-16]  = val;
    else if (idx < 22) m_en[idx-20]     = val;
  endtask

  // {valid, hit, ok, err, win, target, attr, remap}
  function automatic logic [50:0] model(input logic [31:0] a, input logic wr, input logic p);
    logic       hit = 1'b0;
    int         w = 0;
    logic [1:0] ac;
    logic       ok;
    for (int i = NWIN - 1; i >= 0; i--) begin
      logic [15:0] mk = ~m_size[i][31:16];
      if (m_en[p][i] && ((a[31:16] & mk) == (m_base[i][31:16] & mk))) begin
        hit = 1'b1;
        w = i;
      end
    end
    if (!hit) return {1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 4'hF, 8'h00, 32'h0};
    ac = m_en[p][16 + 2*w +: 2];
    ok = wr ? (ac == 2'b11) : (ac == 2'b01 || ac == 2'b11);
    return {1'b1, 1'b1, ok, !ok, 3'(w), m_base[w][3:0], m_base[w][15:8],
            (w < 4) ? m_remap[w] : 32'h0};
  endfunction

  task automatic do_req(input logic [31:0] a, input logic wr, input logic p, input string tag);
    logic [50:0] exp_v, act_v;
    exp_v = model(a, wr, p);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    req_port  = p;
    @(negedge clk);
    req_valid = 1'b0;
    act_v = {rsp_valid, rsp_hit, rsp_ok, rsp_err, rsp_win, rsp_target, rsp_attr, rsp_remap};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d port=%0d actual=%h expected=%h", tag, a, wr, p, act_v, exp_v);
    end
  endtask

  task automatic chk_idle(input string tag);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
      errors++;
      $display("FAIL %s idle actual=%b%b expected=00", tag, rsp_valid, rsp_err);
    end
  endtask

  // window programming
  logic [1:0] acc0 [NWIN] = '{2'b11, 2'b01, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11, 2'b11};
  logic [1:0] acc1 [NWIN] = '{2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11};

  initial begin
    for (int i = 0; i < NWIN; i++) begin m_base[i] = '0; m_size[i] = '0; end
    for (int i = 0; i < 4; i++) m_remap[i] = '0;
    m_en[0] = '0; m_en[1] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk_idle("R1");
    for (int k = 0; k < 16; k++) begin
      do_req({4'(k), 28'h2345678}, k[0], k[1], "R1");
    end
    do_req(32'h0000_0000, 1'b0, 1'b0, "R1");
    chk_idle("R11");

    // R3 R4: program windows
    wr_cfg(0,  {16'h1234, 8'hA5, 8'h03});  wr_cfg(8,  32'h0000_0000);
    wr_cfg(1,  {16'h2000, 8'h11, 8'h05});  wr_cfg(9,  32'h00FF_0000);
    wr_cfg(2,  {16'h2040, 8'h22, 8'h06});  wr_cfg(10, 32'h0000_0000);
    wr_cfg(3,  {16'h3000, 8'h33, 8'h07});  wr_cfg(11, 32'h0FFF_0000);
    wr_cfg(4,  {16'h8000, 8'h44, 8'h09});  wr_cfg(12, 32'h7FFF_0000);
    wr_cfg(5,  {16'h4000, 8'h55, 8'h0A});  wr_cfg(13, 32'h000F_0000);
    wr_cfg(6,  {16'h5000, 8'h66, 8'h0C});  wr_cfg(14, 32'h0000_0000);
    wr_cfg(7,  {16'h2000, 8'h77, 8'h0E});  wr_cfg(15, 32'h00FF_0000);
    for (int r = 0; r < 4; r++) wr_cfg(16 + r, 32'hA000_0000 + 32'(r));
    begin
      logic [31:0] e0, e1;
      e0 = 32'h0000_00F7;
      e1 = 32'h0000_007F;
      for (int i = 0; i < NWIN; i++) begin
        e0[16 + 2*i +: 2] = acc0[i];
        e1[16 + 2*i +: 2] = acc1[i];
      end
      wr_cfg(20, e0);
      wr_cfg(21, e1);
    end

    // directed cases
    do_req(32'h1234_FFFF, 1'b1, 1'b0, "R2");   // 64 KiB window, top of range
    do_req(32'h1235_0000, 1'b0, 1'b0, "R2");   // just beyond
    do_req(32'h1234_0000, 1'b1, 1'b1, "R8");   // read-only on port 1, write refused
    do_req(32'h1234_0000, 1'b0, 1'b1, "R8");
    do_req(32'h2040_1234, 1'b0, 1'b0, "R7");   // windows 1, 2, 7 overlap
    do_req(32'h20FF_0000, 1'b1, 1'b0, "R8");   // window 1 read only on port 0
    do_req(32'h3000_0000, 1'b0, 1'b0, "R5");   // window 3 disabled on port 0
    do_req(32'h3000_0000, 1'b0, 1'b1, "R6");   // enabled on port 1, no access
    do_req(32'h5000_0010, 1'b1, 1'b0, "R6");
    do_req(32'h5000_0010, 1'b1, 1'b1, "R6");
    do_req(32'h4000_0000, 1'b0, 1'b0, "R8");   // reserved access code
    do_req(32'hFFFF_FFFF, 1'b1, 1'b0, "R10");  // window 4, no remap
    do_req(32'h2000_0000, 1'b0, 1'b1, "R10");

    // sweep: every top byte, several middle bytes, both ports and directions
    for (int hi = 0; hi < 256; hi++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] mid;
        mid = (m == 0) ? 8'h00 : (m == 1) ? 8'h34 : (m == 2) ? 8'h40 : 8'hFF;
        for (int v = 0; v < 4; v++) begin
          do_req({8'(hi), mid, 16'hBEEF}, v[0], v[1], "R2");
        end
      end
    end
    chk_idle("R11");

    // R12: override slots must not disturb decode
    wr_cfg(22, 32'hFFFF_FFFF);
    wr_cfg(23, 32'hFFFF_FFFF);
    do_req(32'h1234_0000, 1'b1, 1'b0, "R12");
    do_req(32'h3000_0000, 1'b0, 1'b0, "R12");
    do_req(32'h2040_0000, 1'b0, 1'b1, "R12");
    do_req(32'h9000_0000, 1'b1, 1'b1, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule